// File: doc/BRIEF.md
# Polled ADC Port Bridge

This block connects an analog-to-digital converter to an 8-bit processor I/O bus that has separate read and write strobes. Three consecutive port addresses are decoded. A write to the command port sends a one-clock start pulse to the converter. A read of the status port returns a byte whose lowest bit tells software whether a finished result is waiting. A read of the result port returns the captured sample.

Software starts a conversion and then polls the status port until the done bit is set. It then reads the result port. The block drives the shared data bus only while a read strobe targets the status port or the result port. The bus is modelled as a data value plus an output enable, which stand in for a tri-state buffer.

Address decoding works in two steps. The upper address bits are compared with the group base and act as the decoder enable. The three low bits then pick one of eight decoder lines. With the defaults the group is 80H to 87H: status is at 80H, result at 81H and command at 82H.

Top module: `adc_port_bridge`

## Requirements
- R1: After reset, conv_start and rd_oe are 0, and a read of port 80H returns 00H.
- R2: A write to port 82H makes conv_start high for exactly one clock. The pulse appears in the cycle after the first clock edge that sees the write, however long io_wr stays high. Another pulse needs io_wr to drop first.
- R3: A write to any address other than 82H never raises conv_start. This includes 80H, 81H, 83H and 02H.
- R4: While io_rd is high with address 80H, rd_oe is 1 and rd_data is the status byte. Bit 0 of that byte is the done flag and bits 7 to 1 are 0.
- R5: When conv_ready is sampled high after being sampled low, the done flag reads 1 from the next clock onward.
- R6: A read of 81H returns the conv_data value captured at that rising edge of conv_ready. Later changes of conv_data while conv_ready stays high do not alter it.
- R7: A read of 81H clears the done flag, so the next status read returns 00H.
- R8: Issuing a start pulse clears the done flag.
- R9: rd_oe is 0 and rd_data is 00H for every address other than 80H and 81H. This includes the write-only 82H and the unused 83H to 87H.
- R10: rd_oe is 0 while io_rd is low. Writes to 80H or 81H change neither the done flag nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| rd_data | output | 8 | Read data toward the shared bus |
| rd_oe | output | 1 | Bus drive enable for rd_data |
| conv_start | output | 1 | One-clock start pulse to the converter |
| conv_ready | input | 1 | Converter conversion-complete level |
| conv_data | input | 8 | Converter result |

## Verification
The bench holds the write strobe on 82H for several cycles. A design that used the level instead of the edge would issue repeated start pulses and restart the converter again and again. It also writes to the neighbouring ports. A decoder that ignored the low bits would start conversions from status or result accesses.

Every address in the group, together with addresses outside it, is read back to confirm that the bus stays undriven. A decoder that compared too few upper bits would collide with other peripherals. The bench changes conv_data after ready has risen, and it issues a start while a result is still unread. A design that captured the result continuously, or that never cleared the flag, would return a stale or torn value, or report done before the converter has finished.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  localparam int IO_W = 8;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_RESULT = 2'd2
  } rd_src_e;

  // Status byte: done flag in bit 0, all other bits zero.
  function automatic logic [IO_W-1:0] make_status(input logic done);
    logic [IO_W-1:0] s;
    s = '0;
    s[0] = done;
    return s;
  endfunction
endpackage

// File: rtl/io_port_decode.sv
module io_port_decode #(
  parameter int ADDR_W   = 8,
  parameter int LINE_W   = 3,
  parameter logic [ADDR_W-1:0] BASE = 8'h80,
  parameter int STAT_OFS = 0,
  parameter int RES_OFS  = 1,
  parameter int CMD_OFS  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_status,
  output logic              hit_result,
  output logic              hit_cmd
);
  localparam int LINES = 1 << LINE_W;

  logic              group_en;
  logic [LINES-1:0]  line;

  assign group_en = (addr[ADDR_W-1:LINE_W] == BASE[ADDR_W-1:LINE_W]);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line[i] = group_en && (addr[LINE_W-1:0] == LINE_W'(i));
  end

  assign hit_status = line[STAT_OFS];
  assign hit_result = line[RES_OFS];
  assign hit_cmd    = line[CMD_OFS];

  always_comb begin
    a_r9_one_line: assert ($onehot0(line));
  end
endmodule

// File: rtl/start_pulse_gen.sv
module start_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic sel,
  output logic fire,
  output logic start
);
  logic held_q;

  assign fire = wr && sel && !held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      start  <= 1'b0;
    end else begin
      held_q <= wr && sel;
      start  <= fire;
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  a_r2_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel && $past(wr && sel)) |-> !fire);
endmodule

// File: rtl/conv_tracker.sv
module conv_tracker #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic [DATA_W-1:0] data,
  input  logic              start_fire,
  input  logic              result_read,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic ready_q;
  logic ready_rise;

  assign ready_rise = ready && !ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      ready_q <= ready;
      if (ready_rise) result <= data;
      if (start_fire)       done <= 1'b0;
      else if (ready_rise)  done <= 1'b1;
      else if (result_read) done <= 1'b0;
    end
  end

  a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_rise && !start_fire) |=> done);
  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_rise |=> $stable(result));
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> !done);
endmodule

// File: rtl/read_mux.sv
module read_mux
  import adc_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rd,
  input  logic              hit_status,
  input  logic              hit_result,
  input  logic              done,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] dout,
  output logic              oe
);
  rd_src_e src;

  always_comb begin
    src = SRC_NONE;
    if (rd && hit_status)      src = SRC_STATUS;
    else if (rd && hit_result) src = SRC_RESULT;
  end

  always_comb begin
    unique case (src)
      SRC_STATUS: dout = DATA_W'(make_status(done));
      SRC_RESULT: dout = result;
      default:    dout = '0;
    endcase
  end

  assign oe = (src != SRC_NONE);
endmodule

// File: rtl/adc_port_bridge.sv
module adc_port_bridge
  import adc_bus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = IO_W,
  parameter int LINE_W = 3,
  parameter logic [ADDR_W-1:0] BASE = 8'h80,
  parameter int STAT_OFS = 0,
  parameter int RES_OFS  = 1,
  parameter int CMD_OFS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              conv_start,
  input  logic              conv_ready,
  input  logic [DATA_W-1:0] conv_data
);
  logic              hit_status, hit_result, hit_cmd;
  logic              start_fire;
  logic              result_read;
  logic              done;
  logic [DATA_W-1:0] result;

  io_port_decode #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .BASE(BASE),
    .STAT_OFS(STAT_OFS), .RES_OFS(RES_OFS), .CMD_OFS(CMD_OFS)
  ) u_dec (
    .addr(io_addr), .hit_status(hit_status),
    .hit_result(hit_result), .hit_cmd(hit_cmd)
  );

  start_pulse_gen u_go (
    .clk(clk), .rst_n(rst_n), .wr(io_wr), .sel(hit_cmd),
    .fire(start_fire), .start(conv_start)
  );

  assign result_read = io_rd && hit_result;

  conv_tracker #(.DATA_W(DATA_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .ready(conv_ready), .data(conv_data),
    .start_fire(start_fire), .result_read(result_read),
    .done(done), .result(result)
  );

  read_mux #(.DATA_W(DATA_W)) u_mux (
    .rd(io_rd), .hit_status(hit_status), .hit_result(hit_result),
    .done(done), .result(result), .dout(rd_data), .oe(rd_oe)
  );

  a_r10_oe_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> io_rd);
  a_r9_oe_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (io_addr[ADDR_W-1:LINE_W] == BASE[ADDR_W-1:LINE_W]));
  a_r4_status_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && hit_status) |-> (rd_data[DATA_W-1:1] == '0));
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (result_read && !$rose(conv_ready)) |=> !done);
endmodule

// File: tb/tb_adc_port_bridge.sv
module tb_adc_port_bridge;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] io_addr = 0;
  logic       io_rd = 0, io_wr = 0;
  logic [7:0] rd_data;
  logic       rd_oe, conv_start;
  logic       conv_ready = 0;
  logic [7:0] conv_data = 0;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  adc_port_bridge dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .rd_data(rd_data), .rd_oe(rd_oe),
    .conv_start(conv_start), .conv_ready(conv_ready), .conv_data(conv_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Read a port for one clock; returns data and enable sampled mid-cycle.
  task automatic bus_read(input logic [7:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #2; d = rd_data; oe = rd_oe;
    @(negedge clk);
    io_rd = 0;
  endtask

  // Write for 'hold' clocks; returns the number of start pulses seen.
  task automatic bus_write(input logic [7:0] a, input int hold, output int pulses, output logic first);
    pulses = 0;
    @(negedge clk);
    io_addr = a; io_wr = 1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (i == 0) first = conv_start;
      if (conv_start) pulses++;
    end
    io_wr = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (conv_start) pulses++;
    end
  endtask

  task automatic finish_conv(input logic [7:0] v);
    @(negedge clk); conv_ready = 0; conv_data = v;
    @(negedge clk); conv_ready = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic oe;
    chk("R1 start", conv_start, 0);
    chk("R1 oe", rd_oe, 0);
    bus_read(8'h80, d, oe);
    chk("R1 status", d, 8'h00);
  endtask

  task automatic t_start_pulse();
    int p; logic f;
    bus_write(8'h82, 5, p, f);
    chk("R2 timing", f, 1);
    chk("R2 count", p, 1);
    bus_write(8'h82, 1, p, f);
    chk("R2 second write", p, 1);
  endtask

  task automatic t_other_writes();
    int p; logic f;
    logic [7:0] addrs [4] = '{8'h80, 8'h81, 8'h83, 8'h02};
    foreach (addrs[i]) begin
      bus_write(addrs[i], 2, p, f);
      chk("R3 no pulse", p, 0);
    end
  endtask

  task automatic t_conversion();
    logic [7:0] d; logic oe;
    finish_conv(8'hA5);
    bus_read(8'h80, d, oe);
    chk("R4 oe", oe, 1);
    chk("R5 done", d, 8'h01);
    @(negedge clk); conv_data = 8'h3C;
    bus_read(8'h81, d, oe);
    chk("R6 result", d, 8'hA5);
    bus_read(8'h80, d, oe);
    chk("R7 cleared", d, 8'h00);
  endtask

  task automatic t_start_clears();
    logic [7:0] d; logic oe; int p; logic f;
    finish_conv(8'h5A);
    bus_read(8'h80, d, oe);
    chk("R5 done again", d, 8'h01);
    bus_write(8'h82, 2, p, f);
    bus_read(8'h80, d, oe);
    chk("R8 start clears", d, 8'h00);
    bus_read(8'h81, d, oe);
    chk("R6 result kept", d, 8'h5A);
  endtask

  task automatic t_outside();
    logic [7:0] d; logic oe;
    logic [7:0] addrs [9] = '{8'h82, 8'h83, 8'h84, 8'h85, 8'h86, 8'h87, 8'h00, 8'h88, 8'hC0};
    foreach (addrs[i]) begin
      bus_read(addrs[i], d, oe);
      chk("R9 oe", oe, 0);
      chk("R9 data", d, 8'h00);
    end
  endtask

  task automatic t_no_rd();
    logic [7:0] d; logic oe; int p; logic f;
    finish_conv(8'h77);
    @(negedge clk); io_addr = 8'h80; io_rd = 0; #2;
    chk("R10 oe low 80", rd_oe, 0);
    @(negedge clk); io_addr = 8'h81; #2;
    chk("R10 oe low 81", rd_oe, 0);
    bus_write(8'h80, 2, p, f);
    bus_write(8'h81, 2, p, f);
    bus_read(8'h80, d, oe);
    chk("R10 write ignored", d, 8'h01);
    bus_read(8'h81, d, oe);
    chk("R10 result intact", d, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_start_pulse();
    t_other_writes();
    t_conversion();
    t_start_clears();
    t_outside();
    t_no_rd();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule